// File: doc/BRIEF.md
# Serial Transmitter with In-Field Parity

This block serialises one character at a time onto an asynchronous line. A frame is a low start bit, a data field sent least significant bit first, and a high stop bit. The field is eight or nine bits wide, chosen per frame by a width control. The block takes its bit timing from an external one-cycle rate tick. Each bit on the line lasts exactly one tick period.

When parity is on, the frame does not grow. Instead the top bit of the field is dropped and a computed parity bit goes out in its place. The parity covers the remaining lower field bits. An even or odd sense is selected per frame. The character and all controls are captured when a load is accepted, so the host may change them freely while the frame is on the line.

A load is accepted only while the block is idle. Completion is signalled by a one-cycle pulse after the stop bit, and the busy flag falls on the following cycle.

Top module: `uart_par_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `busy` is 0 and `tx_done` is 0.
- R2: A `tx_load` seen while idle is accepted and raises `busy` on the next cycle. `txd` stays 1 until the next `bit_tick`, which starts the start bit (`txd` = 0) for one tick period.
- R3: After the start bit, the field goes out least significant bit first, one bit per tick period. The field is 8 bits when `frame9` = 0 and 9 bits when `frame9` = 1.
- R4: With `par_en` = 0, the field bits are `tx_data[7:0]` (8-bit frame) or `tx_data[8:0]` (9-bit frame), unchanged.
- R5: With `par_en` = 1, the top field bit (bit 7 for 8-bit frames, bit 8 for 9-bit frames) is not sent from `tx_data`. The parity bit is sent in its place. It covers `tx_data[6:0]` or `tx_data[7:0]` respectively.
- R6: With `par_odd` = 0, the count of ones over the covered bits plus the parity bit is even. With `par_odd` = 1, that count is odd. For example, 0x35 gives parity 0 when even and 1 when odd.
- R7: After the last field bit, `txd` is 1 for one tick period (the stop bit). The tick that ends it raises `tx_done` for exactly one cycle with `busy` still 1. `busy` is 0 on the next cycle.
- R8: A `tx_load` while `busy` is 1 is ignored; the frame in progress is unchanged.
- R9: `tx_data`, `frame9`, `par_en` and `par_odd` are captured at the accepted load. Later changes do not affect the frame being sent.
- R10: `txd` changes only on a clock edge at which `bit_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| tx_data | input | 9 | Character to send (bit 8 used only in 9-bit frames) |
| tx_load | input | 1 | Request to start a frame with the current inputs |
| frame9 | input | 1 | 1 selects a 9-bit field, 0 selects an 8-bit field |
| par_en | input | 1 | 1 replaces the top field bit with parity |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | A frame is accepted and not yet finished |
| tx_done | output | 1 | One-cycle pulse after the stop bit |

## Verification
The bench targets where the parity bit lands and what it covers in each field width. A design that appended parity instead of replacing the top bit would send a longer frame and misplace its stop bit. A design that took parity over the wrong span would disagree on characters whose top data bit is 1. Characters 0x35 and 0xB5 in both senses separate these faults. The bench also reloads and changes every control in mid-frame: a design that did not capture its inputs, or that accepted a load while busy, would corrupt the remaining bits. The done pulse is checked against the stop-bit tick and the busy drop one cycle later.

// File: rtl/uart_par_tx_pkg.sv
package uart_par_tx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_START = 3'd2,
      ST_DATA  = 3'd3,
      ST_STOP  = 3'd4,
      ST_DONE  = 3'd5
   } uptx_state_e;
endpackage

// File: rtl/uptx_parity.sv
module uptx_parity #(
   parameter int DATA_W  = 9,
   parameter int SHORT_W = 8
) (
   input  logic [DATA_W-1:0] data_in,
   input  logic              wide,
   input  logic              par_en,
   input  logic              par_odd,
   output logic [DATA_W-1:0] field_out
);
   logic [DATA_W-1:0] cov_short;
   logic [DATA_W-1:0] cov_long;
   logic              par_bit;

   genvar gi;
   generate
      for (gi = 0; gi < DATA_W; gi++) begin : g_mask
         assign cov_short[gi] = (gi < SHORT_W - 1);
         assign cov_long[gi]  = (gi < DATA_W - 1);
      end
   endgenerate

   assign par_bit = (^(data_in & (wide ? cov_long : cov_short))) ^ par_odd;

   generate
      for (gi = 0; gi < DATA_W; gi++) begin : g_field
         if (gi == DATA_W - 1) begin : g_top_long
            assign field_out[gi] = wide ? (par_en ? par_bit : data_in[gi]) : 1'b0;
         end else if (gi == SHORT_W - 1) begin : g_top_short
            assign field_out[gi] = (!wide && par_en) ? par_bit : data_in[gi];
         end else if (gi < SHORT_W - 1) begin : g_low
            assign field_out[gi] = data_in[gi];
         end else begin : g_mid
            assign field_out[gi] = wide ? data_in[gi] : 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/uptx_shifter.sv
module uptx_shifter #(
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] field_in,
   input  logic              shift,
   output logic              lsb
);
   logic [DATA_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= field_in;
      end else if (shift) begin
         sh_q <= {1'b0, sh_q[DATA_W-1:1]};
      end
   end

   assign lsb = sh_q[0];
endmodule

// File: rtl/uptx_seq.sv
module uptx_seq
   import uart_par_tx_pkg::*;
#(
   parameter int DATA_W  = 9,
   parameter int SHORT_W = 8,
   localparam int CNT_W  = $clog2(DATA_W)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load_req,
   input  logic        bit_tick,
   input  logic        wide,
   output uptx_state_e state,
   output logic        accept,
   output logic        shift_en
);
   localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W - 1);

   uptx_state_e      st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_q;

   assign accept   = load_req && (st_q == ST_IDLE);
   assign shift_en = bit_tick && (st_q == ST_DATA);
   assign state    = st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         last_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (accept) begin
               st_q   <= ST_WAIT;
               last_q <= wide ? LAST_LONG : LAST_SHORT;
            end
            ST_WAIT: if (bit_tick) st_q <= ST_START;
            ST_START: if (bit_tick) begin
               st_q  <= ST_DATA;
               cnt_q <= '0;
            end
            ST_DATA: if (bit_tick) begin
               if (cnt_q == last_q) st_q <= ST_STOP;
               else cnt_q <= cnt_q + 1'b1;
            end
            ST_STOP: if (bit_tick) st_q <= ST_DONE;
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_par_tx.sv
module uart_par_tx
   import uart_par_tx_pkg::*;
#(
   parameter int DATA_W  = 9,
   parameter int SHORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_load,
   input  logic              frame9,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              txd,
   output logic              busy,
   output logic              tx_done
);
   generate
      if (SHORT_W < 2 || SHORT_W >= DATA_W) begin : g_bad_width
         $error("uart_par_tx: need 2 <= SHORT_W < DATA_W");
      end
   endgenerate

   uptx_state_e       state;
   logic              accept;
   logic              shift_en;
   logic              sh_lsb;
   logic [DATA_W-1:0] field;

   uptx_parity #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_parity (
      .data_in  (tx_data),
      .wide     (frame9),
      .par_en   (par_en),
      .par_odd  (par_odd),
      .field_out(field)
   );

   uptx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .field_in(field),
      .shift   (shift_en),
      .lsb     (sh_lsb)
   );

   uptx_seq #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_req(tx_load),
      .bit_tick(bit_tick),
      .wide    (frame9),
      .state   (state),
      .accept  (accept),
      .shift_en(shift_en)
   );

   always_comb begin
      unique case (state)
         ST_START: txd = 1'b0;
         ST_DATA:  txd = sh_lsb;
         default:  txd = 1'b1;
      endcase
   end

   assign busy    = (state != ST_IDLE);
   assign tx_done = (state == ST_DONE);
endmodule

// File: rtl/uart_par_tx_chk.sv
module uart_par_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_tick,
   input logic tx_load,
   input logic txd,
   input logic busy,
   input logic tx_done
);
   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (txd && !tx_done));

   p_accept_line_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && tx_load) |=> (busy && txd));

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> (!tx_done && !busy));

   p_done_with_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> busy);

   p_load_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tx_done && tx_load) |=> busy);

   p_line_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(txd));
endmodule

bind uart_par_tx uart_par_tx_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bit_tick(bit_tick),
   .tx_load (tx_load),
   .txd     (txd),
   .busy    (busy),
   .tx_done (tx_done)
);

// File: tb/tb_uart_par_tx.sv
module tb_uart_par_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic [8:0] tx_data = '0;
   logic       tx_load = 1'b0;
   logic       frame9 = 1'b0;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       txd;
   logic       busy;
   logic       tx_done;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   uart_par_tx dut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_data(tx_data),
      .tx_load(tx_load), .frame9(frame9), .par_en(par_en), .par_odd(par_odd),
      .txd(txd), .busy(busy), .tx_done(tx_done)
   );

   // {data[8:0], frame9, par_en, par_odd}
   localparam logic [11:0] VEC [10] = '{
      {9'h035, 3'b010},   // R6 even example, 8-bit
      {9'h035, 3'b011},   // R6 odd example, 8-bit
      {9'h0B5, 3'b010},   // R5 top bit dropped
      {9'h0B5, 3'b000},   // R4 no parity
      {9'h135, 3'b110},   // R5 9-bit even
      {9'h035, 3'b111},   // R6 9-bit odd
      {9'h1FF, 3'b100},   // R4 9-bit plain
      {9'h0FF, 3'b111},   // R5 9-bit odd, 8 ones
      {9'h07F, 3'b011},   // R6 8-bit odd, 7 ones
      {9'h000, 3'b010}    // R6 zero even
   };

   task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [8:0] exp_field(input logic [8:0] d, input logic w9,
                                            input logic pe, input logic po);
      logic [8:0] f;
      int         top;
      top = w9 ? 8 : 7;
      f = w9 ? d : {1'b0, d[7:0]};
      if (pe) begin
         f[top] = 1'b0;
         f[top] = ($countones(f) % 2 == 1) ^ po;
      end
      return f;
   endfunction

   task automatic tick();
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
   endtask

   task automatic send(input logic [8:0] d, input logic w9, input logic pe,
                       input logic po, input bit meddle);
      logic [8:0] f;
      int         n;
      f = exp_field(d, w9, pe, po);
      n = w9 ? 9 : 8;
      @(negedge clk);
      tx_data = d; frame9 = w9; par_en = pe; par_odd = po; tx_load = 1'b1;
      @(negedge clk) tx_load = 1'b0;
      chk("R2 busy after accept", {8'd0, busy}, 9'd1);
      chk("R2 line high before first tick", {8'd0, txd}, 9'd1);
      if (meddle) begin
         // R8 R9: reload with different data and controls mid-frame
         tx_data = ~d; frame9 = ~w9; par_en = ~pe; par_odd = ~po; tx_load = 1'b1;
      end
      tick();
      chk("R2 start bit", {8'd0, txd}, 9'd0);
      for (int i = 0; i < n; i++) begin
         tick();
         if (meddle && i == 2) tx_load = 1'b0;
         chk(meddle ? "R8 R9 field bit" : "R3 R4 R5 field bit", {8'd0, txd}, {8'd0, f[i]});
      end
      tx_load = 1'b0;
      tick();
      chk("R7 stop bit", {8'd0, txd}, 9'd1);
      chk("R7 no early done", {8'd0, tx_done}, 9'd0);
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
      chk("R7 done pulse", {7'd0, tx_done, busy}, 9'd3);
      @(negedge clk);
      chk("R7 busy drops after done", {7'd0, tx_done, busy}, 9'd0);
      chk("R1 idle line", {8'd0, txd}, 9'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset line", {7'd0, txd, busy}, 9'd2);
      chk("R1 reset done", {8'd0, tx_done}, 9'd0);
      rst_n = 1'b1;
      @(negedge clk);
      tick();
      chk("R1 idle after tick", {6'd0, txd, busy, tx_done}, 9'd4);

      for (int v = 0; v < 10; v++) begin
         send(VEC[v][11:3], VEC[v][2], VEC[v][1], VEC[v][0], 1'b0);
      end

      // R8 R9 corner cases: interference during 8-bit and 9-bit frames
      send(9'h0A6, 1'b0, 1'b1, 1'b0, 1'b1);
      send(9'h12C, 1'b1, 1'b1, 1'b1, 1'b1);
      send(9'h0B5, 1'b0, 1'b0, 1'b0, 1'b1);

      // R10: line holds between ticks within a frame
      @(negedge clk);
      tx_data = 9'h001; frame9 = 1'b0; par_en = 1'b0; par_odd = 1'b0; tx_load = 1'b1;
      @(negedge clk) tx_load = 1'b0;
      tick();
      tick();
      repeat (5) @(negedge clk);
      chk("R10 line held between ticks", {8'd0, txd}, 9'd1);
      for (int k = 0; k < 10; k++) tick();
      @(negedge clk);
      chk("R10 frame finished", {8'd0, busy}, 9'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule